// File: doc/BRIEF.md
# Flow-Controlled Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial characters on a single output line. A producer hands over one byte, and optionally a ninth address-marker bit, through a valid/ready handshake. The block keeps that byte in a one-entry holding register. It then sends a frame made of a low start bit, the eight data bits with the least significant bit first, an optional marker bit, and one or two high stop bits. The length of every bit is set in system clocks by a 16-bit divisor.

A clear-to-send input can hold off the next character. The input is active low and passes through a two-flop synchronizer. It is looked at only in the single idle clock just before a character would start, so a character that has already begun always finishes. A busy flag and a one-cycle done pulse let the surrounding logic follow progress. Configuration inputs are captured at the start of each character and are expected to change only while the block is idle.

Top module: `uart_cts_tx`

## Requirements
- R1: Out of reset, `txd` is 1, `busy` is 0, `in_ready` is 1 and `done` is 0. `txd` stays 1 whenever no character is being sent.
- R2: A frame starts with one bit at 0, followed by data bits 0 through 7 in that order. Every bit lasts D = max(`cfg_div`, 1) clocks.
- R3: With `cfg_mp_en` = 1, the value of `in_mp` is sent as one bit between data bit 7 and the first stop bit.
- R4: With `cfg_mp_en` = 0, no marker bit is sent, and the stop bits follow data bit 7 directly.
- R5: The frame ends with two bits at 1 when `cfg_two_stop` = 1, and with one bit at 1 otherwise.
- R6: A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when nothing is pending and the line is either idle or in the last clock of the final stop bit. It is low in the cycle after a byte is taken.
- R7: When clear-to-send permits, the start bit appears on the second rising edge after the byte is taken. This means back-to-back characters are separated by exactly one extra clock at 1.
- R8: With `cfg_cts_en` = 1, a high `cts_n` keeps a pending character from starting, and `busy` stays 1 while it waits. After `cts_n` falls, the start bit appears on the third rising edge.
- R9: If `cts_n` rises while a character is being sent, that character still completes in full, including its stop bits.
- R10: With `cfg_cts_en` = 0, `cts_n` has no effect, and the timing of R7 holds even while `cts_n` is 1.
- R11: `done` is high for exactly one clock, in the clock right after the final stop bit period. `busy` is high from the byte being taken until the end of that stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cts_en | input | 1 | Enables clear-to-send gating |
| cfg_mp_en | input | 1 | Enables the ninth marker bit |
| cfg_two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| cfg_div | input | 16 | Clocks per bit (0 acts as 1) |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| in_valid | input | 1 | Producer offers a byte |
| in_data | input | 8 | Byte to send |
| in_mp | input | 1 | Marker bit for this byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A character is pending or in flight |
| done | output | 1 | One-cycle pulse at the end of a character |

## Verification
Two events can fall on the same cycle: taking the next byte and ending the current character. The handshake can land on the very clock that finishes the final stop bit, so the done pulse and the refill of the holding register happen together. The bench provokes this by holding `in_valid` high across streams of bytes with random divisors and frame shapes. It judges the result by requiring each start bit exactly two edges after its handshake, `done` exactly one clock after the last stop bit, and every frame bit correct at its mid-point.

// File: rtl/uart_cts_tx.sv
module uart_cts_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int SYNC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cts_en,
  input  logic              cfg_mp_en,
  input  logic              cfg_two_stop,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cts_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mp,
  output logic              in_ready,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic [SYNC_W-1:0]  cts_pipe;
  logic               cts_sync;
  logic               pend, active;
  logic [DATA_W-1:0]  hold_data;
  logic               hold_mp;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;
  logic [DIV_W-1:0]   cnt, div_q;
  logic [DIV_W-1:0]   div_eff;
  logic               cts_ok, last_tick, take, launch;

  assign cts_sync  = cts_pipe[SYNC_W-1];
  assign cts_ok    = !cfg_cts_en || !cts_sync;
  assign div_eff   = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
  assign last_tick = active && (cnt == '0) && (left == '0);
  assign in_ready  = !pend && (!active || last_tick);
  assign take      = in_valid && in_ready;
  assign launch    = !active && pend && cts_ok;
  assign txd       = active ? sh[0] : 1'b1;
  assign busy      = active || pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cts_pipe <= '1;
    else        cts_pipe <= {cts_pipe[SYNC_W-2:0], cts_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend      <= 1'b0;
      hold_data <= '0;
      hold_mp   <= 1'b0;
    end else if (take) begin
      pend      <= 1'b1;
      hold_data <= in_data;
      hold_mp   <= in_mp;
    end else if (launch) begin
      pend      <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      sh     <= '1;
      left   <= '0;
      cnt    <= '0;
      div_q  <= DIV_W'(1);
      done   <= 1'b0;
    end else begin
      done <= last_tick;
      if (launch) begin
        active <= 1'b1;
        sh     <= {2'b11, cfg_mp_en ? hold_mp : 1'b1, hold_data, 1'b0};
        left   <= CNT_W'(DATA_W + 1) + CNT_W'(cfg_mp_en) + CNT_W'(cfg_two_stop);
        div_q  <= div_eff;
        cnt    <= div_eff - DIV_W'(1);
      end else if (active) begin
        if (cnt != '0) begin
          cnt <= cnt - DIV_W'(1);
        end else if (left == '0) begin
          active <= 1'b0;
        end else begin
          sh   <= {1'b1, sh[FRAME_W-1:1]};
          left <= left - CNT_W'(1);
          cnt  <= div_q - DIV_W'(1);
        end
      end
    end
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic busy,
  input logic done,
  input logic in_valid,
  input logic in_ready,
  input logic cfg_cts_en,
  input logic active,
  input logic cts_sync
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_take_blocks_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && busy));

  assert_cts_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && $past(cfg_cts_en)) |-> !$past(cts_sync));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_line_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> txd);

  assert_done_after_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(active) && !active));
endmodule

bind uart_cts_tx uart_cts_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .busy(busy), .done(done),
  .in_valid(in_valid), .in_ready(in_ready), .cfg_cts_en(cfg_cts_en),
  .active(active), .cts_sync(cts_sync)
);

// File: tb/uart_cts_tx_bench.sv
module uart_cts_tx_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_cts_en = 0, cfg_mp_en = 0, cfg_two_stop = 0;
  logic [15:0] cfg_div = 16'd1;
  logic cts_n = 0, in_valid = 0, in_mp = 0;
  logic [7:0] in_data = 0;
  logic in_ready, txd, busy, done;

  uart_cts_tx u_uart_cts_tx (
    .clk(clk), .rst_n(rst_n), .cfg_cts_en(cfg_cts_en), .cfg_mp_en(cfg_mp_en),
    .cfg_two_stop(cfg_two_stop), .cfg_div(cfg_div), .cts_n(cts_n),
    .in_valid(in_valid), .in_data(in_data), .in_mp(in_mp),
    .in_ready(in_ready), .txd(txd), .busy(busy), .done(done));

  always #5 clk = ~clk;

  typedef struct packed {
    logic        mp_en;
    logic        two;
    logic [15:0] div;
    logic        mp;
    logic [7:0]  data;
    int          acc;
    logic        lat;
  } item_t;

  item_t q[$];
  int cyc = 0, total = 0, bad = 0;
  bit in_frame = 0;
  int last_start = 0;
  int last_acc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int dur(input logic [15:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  function automatic int nbits(input item_t it);
    return 10 + int'(it.mp_en) + int'(it.two);
  endfunction

  function automatic logic exp_bit(input item_t it, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return it.data[k-1];
    if (k == 9 && it.mp_en) return it.mp;
    return 1'b1;
  endfunction

  function automatic string bit_req(input item_t it, input int k);
    if (k <= 8) return "R2";
    if (k == 9 && it.mp_en) return "R3";
    if (k == 9) return "R4";
    return "R5";
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // frame monitor
  initial begin
    item_t cur;
    int s, d, n, idx;
    cur = '0; s = 0; d = 1; n = 10;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!in_frame && done) check(0, "R11 stray done", 1, 0);
        if (!in_frame && !txd) begin
          if (q.size() == 0) check(0, "R1 unexpected start", 0, 1);
          else begin
            cur = q.pop_front();
            in_frame = 1; s = cyc; last_start = cyc;
            d = dur(cur.div); n = nbits(cur);
            if (cur.lat) check(s == cur.acc + 2, "R7 start latency", s - cur.acc, 2);
          end
        end
        if (in_frame) begin
          idx = cyc - s;
          if (idx < n * d) begin
            if (done) check(0, "R11 early done", 1, 0);
            if (!busy) check(0, "R11 busy in frame", 0, 1);
            if (idx % d == d / 2)
              check(txd == exp_bit(cur, idx / d), bit_req(cur, idx / d), txd, exp_bit(cur, idx / d));
          end else begin
            check(done == 1'b1, "R11 done at end", done, 1);
            check(txd == 1'b1, "R5 line after stop", txd, 1);
            in_frame = 0;
          end
        end
      end
    end
  end

  task automatic send(input logic [7:0] dv, input logic m, input bit keep, input bit lat);
    item_t it;
    in_valid = 1; in_data = dv; in_mp = m;
    while (!in_ready) @(negedge clk);
    it.mp_en = cfg_mp_en; it.two = cfg_two_stop; it.div = cfg_div;
    it.mp = m; it.data = dv; it.acc = cyc; it.lat = lat;
    last_acc = cyc;
    q.push_back(it);
    @(negedge clk);
    check(!in_ready, "R6 ready drops after take", in_ready, 0);
    if (!keep) in_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy || in_frame) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check(txd == 1, "R1 reset txd", txd, 1);
    check(busy == 0, "R1 reset busy", busy, 0);
    check(in_ready == 1, "R1 reset ready", in_ready, 1);
    check(done == 0, "R1 reset done", done, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // directed frames
    cfg_div = 16'd3; send(8'hA5, 1'b1, 0, 1); wait_idle();
    cfg_div = 16'd0; cfg_mp_en = 1; cfg_two_stop = 1; send(8'h3C, 1'b1, 0, 1); wait_idle();
    cfg_mp_en = 1; cfg_two_stop = 0; cfg_div = 16'd4; send(8'h81, 1'b0, 0, 1); wait_idle();
    // streaming: handshake on the final stop clock together with done
    cfg_mp_en = 0; cfg_two_stop = 0; cfg_div = 16'd2;
    send(8'h01, 0, 1, 1); send(8'hFE, 0, 1, 1); send(8'h55, 0, 1, 1); send(8'hAA, 0, 0, 1);
    wait_idle();

    // R8: hold-off while cts_n high
    cfg_cts_en = 1; cts_n = 1; repeat (4) @(negedge clk);
    send(8'h96, 1'b0, 0, 0);
    begin
      bit stayed = 1;
      repeat (40) begin @(negedge clk); if (!txd) stayed = 0; end
      check(stayed, "R8 held off", 0, 1);
      check(busy == 1, "R8 busy while held", busy, 1);
      check(in_ready == 0, "R8 ready while held", in_ready, 0);
    end
    begin
      int rel;
      cts_n = 0; rel = cyc;
      while (txd) @(negedge clk);
      check(cyc - rel == 3, "R8 release latency", cyc - rel, 3);
    end
    wait_idle();

    // R9: deassert mid-character, next one waits
    cfg_div = 16'd3; cfg_two_stop = 1;
    send(8'h5A, 1'b0, 0, 1);
    while (txd) @(negedge clk);
    repeat (5) @(negedge clk);
    cts_n = 1;
    send(8'hC3, 1'b0, 0, 0);
    while (in_frame) @(negedge clk);
    begin
      bit stayed = 1;
      repeat (30) begin @(negedge clk); if (!txd) stayed = 0; end
      check(stayed, "R9 second held after first completes", 0, 1);
      check(q.size() == 1, "R9 first frame completed", q.size(), 1);
    end
    cts_n = 0; wait_idle();

    // R10: cts ignored when disabled
    cfg_cts_en = 0; cts_n = 1; repeat (4) @(negedge clk);
    send(8'h3E, 1'b0, 0, 1);
    while (txd) @(negedge clk);
    check(cyc - last_acc == 2, "R10 cts ignored", cyc - last_acc, 2);
    wait_idle();
    cts_n = 0;

    // random bursts
    for (int b = 0; b < 40; b++) begin
      cfg_div      = 16'($urandom_range(0, 6));
      cfg_mp_en    = 1'($urandom_range(0, 1));
      cfg_two_stop = 1'($urandom_range(0, 1));
      cfg_cts_en   = 1'($urandom_range(0, 1));
      repeat (4) @(negedge clk);
      begin
        int len = $urandom_range(1, 4);
        bit b2b = 1'($urandom_range(0, 1));
        for (int k = 0; k < len; k++)
          send(8'($urandom), 1'($urandom_range(0, 1)), b2b && (k != len - 1), 1);
      end
      wait_idle();
    end

    check(q.size() == 0, "R2 all frames seen", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule